// File: doc/BRIEF.md
# Periodic Sampling Delay Scheduler

This block paces conversion requests for a bank of eight ADC conversion slots. It contains four independent delay channels, each programmed through a 32-bit control word. Once a channel is started by its kick bit, it counts base-rate ticks and, at the end of every period, sends a one-cycle trigger to each conversion slot named in its slot mask. The tick input is an enable pulse that arrives at the sampling base rate, nominally 2 kHz, so a delay of 200 gives one trigger burst every 100 ms.

A channel repeats its period for a programmed number of loops and then stops by clearing its own kick bit. On its final period it can also kick any channels named in its chain mask. A channel that names itself in that mask runs without end. For example, a loop count of 4 and a period of 200 ticks gives five conversions per slot, so a consumer that accumulates those five gets one result set every 500 ms.

Software updates a channel's control word in one of three ways. It can write the whole word, OR bits into it, or clear bits from it, so a single bit changes without a read-modify-write.

Top module: `schedTop`

## Requirements
- R1: After reset every channel's control word reads as zero and `slotTrig` is zero.
- R2: The control word fields are: delay in bits 10:0, loop count in bits 15:11, chain mask in bits 19:16 (bit 16+k names channel k), kick in bit 20, slot mask in bits 31:24 (bit 24+s names slot s). Bits 23:21 read zero. `regWrOp` 0 replaces the word, 1 ORs `regWrData` into it, 2 clears the bits set in `regWrData`, and 3 has no effect.
- R3: When a channel's kick goes from 0 to 1, its first firing happens on the D-th tick after that edge, and later firings come every D ticks, where D is the delay field. A delay of 0 or 1 fires on every tick. Clock cycles without `tickEn` do not count.
- R4: A firing raises the channel's slot-mask bits on `slotTrig` for exactly one cycle, in the cycle after the tick edge that caused it. Firings of several channels in the same cycle are ORed together.
- R5: A channel with loop count L fires L+1 times and then clears its own kick bit. The chain mask can override this (R6).
- R6: On its final firing, a channel kicks every channel in its chain mask. Each such channel restarts from its programmed delay and loop count with its kick bit set. A channel that names itself keeps running continuously with its kick bit held at 1.
- R7: Clearing the kick bit stops the channel: it gives no firing from that write onward, and writing the word to zero also disables it. Writing kick=1 to a channel that is already running does not restart its count.
- R8: If a software write to a channel and a chain kick into that channel happen in the same cycle, the write decides the channel's word and kick bit, and the chain kick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle enable at the sampling base rate |
| regWrEn | input | 1 | Control word write strobe |
| regWrOp | input | 2 | Write kind: 0 replace, 1 set bits, 2 clear bits, 3 none |
| regWrChan | input | 2 | Channel addressed by the write |
| regWrData | input | 32 | Write data |
| regRdChan | input | 2 | Channel whose word appears on regRdData |
| regRdData | output | 32 | Control word of the addressed channel (combinational) |
| slotTrig | output | 8 | One-cycle trigger per conversion slot |

## Verification
The block's field widths are fixed constants, so the bench builds it at its default shape: four channels and eight slots. It then keeps every programmed delay below six ticks and every loop count below four. This short scale lets one run cover many complete loop sequences and chain hand-offs, both with ticks every cycle and with ticks that arrive at random. It also reaches the rare cases where a write lands in the same cycle as a final firing or a chain kick, which a real-time delay would almost never hit.

// File: rtl/schedPkg.sv
package schedPkg;

  // Geometry fixed by the control word layout
  localparam int CH_N   = 4;
  localparam int SLOT_N = 8;
  localparam int DLY_W  = 11;
  localparam int LOOP_W = 5;
  localparam int WORD_W = 32;
  localparam int CH_W   = $clog2(CH_N);

  // Field positions (software-visible layout)
  localparam int DLY_LSB   = 0;
  localparam int LOOP_LSB  = DLY_LSB + DLY_W;
  localparam int DTRIG_LSB = 16;
  localparam int KICK_BIT  = DTRIG_LSB + CH_N;
  localparam int STRIG_LSB = 24;
  localparam int GAP_W     = STRIG_LSB - KICK_BIT - 1;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } wrOp_e;

  typedef struct packed {
    logic [SLOT_N-1:0] strig;
    logic              kick;
    logic [CH_N-1:0]   dtrig;
    logic [LOOP_W-1:0] loops;
    logic [DLY_W-1:0]  dly;
  } chanCfg_t;

  // Control -> datapath strobes, one bit per channel
  typedef struct packed {
    logic [CH_N-1:0] wrSel;
    logic [CH_N-1:0] start;
    logic [CH_N-1:0] fire;
    logic [CH_N-1:0] last;
    logic [CH_N-1:0] count;
    logic [CH_N-1:0] stop;
  } chStrobe_t;

  function automatic logic [WORD_W-1:0] cfgToWord(input chanCfg_t c);
    return {c.strig, {GAP_W{1'b0}}, c.kick, c.dtrig, c.loops, c.dly};
  endfunction

  function automatic chanCfg_t wordToCfg(input logic [WORD_W-1:0] w);
    chanCfg_t c;
    c.dly   = w[DLY_LSB   +: DLY_W];
    c.loops = w[LOOP_LSB  +: LOOP_W];
    c.dtrig = w[DTRIG_LSB +: CH_N];
    c.kick  = w[KICK_BIT];
    c.strig = w[STRIG_LSB +: SLOT_N];
    return c;
  endfunction

endpackage

// File: rtl/schedControl.sv
module schedControl
  import schedPkg::*;
(
  input  logic                 tickEn,
  input  logic                 wrEn,
  input  logic [1:0]           wrOp,
  input  logic [CH_W-1:0]      wrChan,
  input  logic                 wrKickNew,
  input  logic [CH_N-1:0]      kickVec,
  input  logic [CH_N*CH_N-1:0] dtrigFlat,
  input  logic [CH_N-1:0]      cntLow,
  input  logic [CH_N-1:0]      loopZero,
  output chStrobe_t            strb
);

  logic [CH_N-1:0] active;
  logic [CH_N-1:0] chainIn;

  always_comb begin
    strb    = '0;
    active  = '0;
    chainIn = '0;
    // per-channel period decisions
    for (int c = 0; c < CH_N; c++) begin
      strb.wrSel[c] = wrEn && (wrOp != OP_NONE) && (wrChan == CH_W'(c));
      // a write that clears kick stops the channel in its own cycle
      active[c]     = kickVec[c] && !(strb.wrSel[c] && !wrKickNew);
      strb.fire[c]  = active[c] && tickEn && cntLow[c];
      strb.count[c] = active[c] && tickEn && !cntLow[c];
      strb.last[c]  = strb.fire[c] && loopZero[c];
    end
    // chain kicks from channels finishing their last loop
    for (int t = 0; t < CH_N; t++) begin
      for (int k = 0; k < CH_N; k++) begin
        if (strb.last[k] && dtrigFlat[k*CH_N + t]) chainIn[t] = 1'b1;
      end
    end
    for (int c = 0; c < CH_N; c++) begin
      strb.start[c] = (strb.wrSel[c] && wrKickNew && !kickVec[c]) ||
                      (!strb.wrSel[c] && chainIn[c]);
      strb.stop[c]  = strb.last[c] && !chainIn[c] && !strb.wrSel[c];
    end
  end

endmodule

// File: rtl/schedDatapath.sv
module schedDatapath
  import schedPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           wrOp,
  input  logic [CH_W-1:0]      wrChan,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [CH_W-1:0]      rdChan,
  input  chStrobe_t            strb,
  output logic [WORD_W-1:0]    rdData,
  output logic                 wrKickNew,
  output logic [CH_N-1:0]      kickVec,
  output logic [CH_N*CH_N-1:0] dtrigFlat,
  output logic [CH_N-1:0]      cntLow,
  output logic [CH_N-1:0]      loopZero,
  output logic [SLOT_N-1:0]    slotTrig
);

  chanCfg_t cfgAll [CH_N];
  chanCfg_t wrCfg;
  chanCfg_t curCfg;
  chanCfg_t nextCfg;
  logic     unusedGapBits;

  assign unusedGapBits = ^wrData[KICK_BIT+1 +: GAP_W];

  // merge of the write with the addressed word
  always_comb begin
    wrCfg  = wordToCfg(wrData);
    curCfg = cfgAll[wrChan];
    unique case (wrOp)
      OP_WRITE: nextCfg = wrCfg;
      OP_SET:   nextCfg = chanCfg_t'(curCfg | wrCfg);
      OP_CLEAR: nextCfg = chanCfg_t'(curCfg & ~wrCfg);
      default:  nextCfg = curCfg;
    endcase
  end

  assign wrKickNew = nextCfg.kick;

  for (genvar c = 0; c < CH_N; c++) begin : gCh
    chanCfg_t          cfgR;
    logic [DLY_W-1:0]  cntR;
    logic [LOOP_W-1:0] loopR;
    logic [DLY_W-1:0]  srcDly;
    logic [LOOP_W-1:0] srcLoops;

    assign srcDly   = strb.wrSel[c] ? nextCfg.dly   : cfgR.dly;
    assign srcLoops = strb.wrSel[c] ? nextCfg.loops : cfgR.loops;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgR  <= '0;
        cntR  <= '0;
        loopR <= '0;
      end else begin
        if (strb.wrSel[c])      cfgR      <= nextCfg;
        else if (strb.start[c]) cfgR.kick <= 1'b1;
        else if (strb.stop[c])  cfgR.kick <= 1'b0;

        if (strb.start[c]) begin
          cntR  <= srcDly;
          loopR <= srcLoops;
        end else if (strb.fire[c]) begin
          cntR <= cfgR.dly;
          if (!strb.last[c]) loopR <= loopR - LOOP_W'(1);
        end else if (strb.count[c]) begin
          cntR <= cntR - DLY_W'(1);
        end
      end
    end

    assign cfgAll[c]                   = cfgR;
    assign kickVec[c]                  = cfgR.kick;
    assign dtrigFlat[c*CH_N +: CH_N]   = cfgR.dtrig;
    assign cntLow[c]                   = (cntR <= DLY_W'(1));
    assign loopZero[c]                 = (loopR == '0);
  end

  assign rdData = cfgToWord(cfgAll[rdChan]);

  // slot trigger register
  logic [SLOT_N-1:0] slotNext;
  always_comb begin
    slotNext = '0;
    for (int c = 0; c < CH_N; c++) begin
      if (strb.fire[c]) slotNext = slotNext | cfgAll[c].strig;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) slotTrig <= '0;
    else       slotTrig <= slotNext;
  end

endmodule

// File: rtl/schedTop.sv
module schedTop
  import schedPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        regWrEn,
  input  logic [1:0]  regWrOp,
  input  logic [1:0]  regWrChan,
  input  logic [31:0] regWrData,
  input  logic [1:0]  regRdChan,
  output logic [31:0] regRdData,
  output logic [7:0]  slotTrig
);

  chStrobe_t            strb;
  logic                 wrKickNew;
  logic [CH_N-1:0]      kickVec;
  logic [CH_N*CH_N-1:0] dtrigFlat;
  logic [CH_N-1:0]      cntLow;
  logic [CH_N-1:0]      loopZero;

  schedControl u_ctl (
    .tickEn    (tickEn),
    .wrEn      (regWrEn),
    .wrOp      (regWrOp),
    .wrChan    (regWrChan),
    .wrKickNew (wrKickNew),
    .kickVec   (kickVec),
    .dtrigFlat (dtrigFlat),
    .cntLow    (cntLow),
    .loopZero  (loopZero),
    .strb      (strb)
  );

  schedDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrOp      (regWrOp),
    .wrChan    (regWrChan),
    .wrData    (regWrData),
    .rdChan    (regRdChan),
    .strb      (strb),
    .rdData    (regRdData),
    .wrKickNew (wrKickNew),
    .kickVec   (kickVec),
    .dtrigFlat (dtrigFlat),
    .cntLow    (cntLow),
    .loopZero  (loopZero),
    .slotTrig  (slotTrig)
  );

endmodule

// File: rtl/schedChk.sv
module schedChk (
  input logic        clk,
  input logic        rstN,
  input logic        tickEn,
  input logic        regWrEn,
  input logic [1:0]  regWrOp,
  input logic [1:0]  regWrChan,
  input logic [31:0] regWrData,
  input logic [3:0]  kickVec,
  input logic [7:0]  slotTrig
);

  // a trigger only follows a tick edge
  p_tick_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (slotTrig != 8'h00) |-> $past(tickEn));

  // no channel running means no trigger next cycle
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(|kickVec) |-> (slotTrig == 8'h00));

  // clearing the kick bit stops the channel at once
  p_clear_stops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrOp == 2'd2 && regWrData[20]) |=> !kickVec[$past(regWrChan)]);

  // setting the kick bit leaves the channel running
  p_set_kick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrOp == 2'd1 && regWrData[20]) |=> kickVec[$past(regWrChan)]);

endmodule

bind schedTop schedChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .regWrEn   (regWrEn),
  .regWrOp   (regWrOp),
  .regWrChan (regWrChan),
  .regWrData (regWrData),
  .kickVec   (kickVec),
  .slotTrig  (slotTrig)
);

// File: tb/sim_schedTop.sv
`timescale 1ns/100ps
module sim_schedTop;

  localparam int KICK = 32'h0010_0000;
  localparam int MASK = 32'hFF1F_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrOp = 2'd0;
  logic [1:0]  regWrChan = 2'd0;
  logic [31:0] regWrData = '0;
  logic [1:0]  regRdChan = 2'd0;
  logic [31:0] regRdData;
  logic [7:0]  slotTrig;

  int total = 0;
  int bad = 0;

  schedTop u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regWrOp(regWrOp), .regWrChan(regWrChan), .regWrData(regWrData),
    .regRdChan(regRdChan), .regRdData(regRdData), .slotTrig(slotTrig)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mWord [4];
  int mCnt  [4];
  int mLoop [4];
  int mSlot;

  function automatic int fDly(int w);   return w & 32'h7FF; endfunction
  function automatic int fLoop(int w);  return (w >> 11) & 31; endfunction
  function automatic int fDtrig(int w); return (w >> 16) & 15; endfunction
  function automatic int fKick(int w);  return (w >> 20) & 1; endfunction
  function automatic int fStrig(int w); return (w >> 24) & 255; endfunction

  always @(posedge clk) begin
    int sw[4], nw[4], act[4], fire[4], last[4], chain[4], cur[4];
    if (!rstN) begin
      for (int c = 0; c < 4; c++) begin mWord[c] = 0; mCnt[c] = 0; mLoop[c] = 0; end
      mSlot = 0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        int d;
        cur[c] = mWord[c];
        sw[c] = (regWrEn && regWrOp != 2'd3 && regWrChan == c) ? 1 : 0;
        d = regWrData & MASK;
        if (regWrOp == 2'd0) nw[c] = d;
        else if (regWrOp == 2'd1) nw[c] = cur[c] | d;
        else nw[c] = cur[c] & ~d;
        act[c]  = (fKick(cur[c]) == 1 && !(sw[c] == 1 && fKick(nw[c]) == 0)) ? 1 : 0;
        fire[c] = (act[c] == 1 && tickEn && mCnt[c] <= 1) ? 1 : 0;
        last[c] = (fire[c] == 1 && mLoop[c] == 0) ? 1 : 0;
      end
      mSlot = 0;
      for (int c = 0; c < 4; c++) if (fire[c] == 1) mSlot |= fStrig(cur[c]);
      for (int t = 0; t < 4; t++) begin
        chain[t] = 0;
        for (int k = 0; k < 4; k++)
          if (last[k] == 1 && ((fDtrig(cur[k]) >> t) & 1) == 1) chain[t] = 1;
      end
      for (int c = 0; c < 4; c++) begin
        bit st;
        st = (sw[c] == 1 && fKick(nw[c]) == 1 && fKick(cur[c]) == 0) ||
             (sw[c] == 0 && chain[c] == 1);
        if (sw[c] == 1) mWord[c] = nw[c];
        if (st) begin
          mWord[c] |= KICK;
          mCnt[c]  = fDly(mWord[c]);
          mLoop[c] = fLoop(mWord[c]);
        end else if (fire[c] == 1) begin
          mCnt[c] = fDly(cur[c]);
          if (last[c] == 1) begin
            if (sw[c] == 0) mWord[c] &= ~KICK;
          end else mLoop[c] = mLoop[c] - 1;
        end else if (act[c] == 1 && tickEn) begin
          mCnt[c] = mCnt[c] - 1;
        end
      end
    end
  end

  // ---------------- per-cycle compare and observation ----------------
  logic [31:0] dutWord [4];
  int slotCnt [8];

  always @(negedge clk) begin
    for (int b = 0; b < 8; b++) slotCnt[b] += slotTrig[b];
    for (int c = 0; c < 4; c++) begin
      regRdChan = 2'(c);
      #0.2;
      dutWord[c] = regRdData;
    end
    if (rstN) begin
      chk(slotTrig == 8'(mSlot), "R4 slotTrig vs model", {24'h0, slotTrig}, mSlot);
      for (int c = 0; c < 4; c++)
        chk(dutWord[c] == 32'(mWord[c]), "R2 word vs model", dutWord[c], mWord[c]);
    end
  end

  task automatic clrCnt();
    for (int b = 0; b < 8; b++) slotCnt[b] = 0;
  endtask

  // called at negedge+1; returns one cycle later at negedge+1
  task automatic wr(input int ch, input int op, input logic [31:0] data);
    regWrEn = 1'b1; regWrChan = 2'(ch); regWrOp = 2'(op); regWrData = data;
    @(negedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    for (int b = 0; b < 8; b++) slotCnt[b] = 0;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    idle(1);
    // R1: reset state
    for (int c = 0; c < 4; c++) chk(dutWord[c] == 32'h0, "R1 word after reset", dutWord[c], 0);
    chk(slotTrig == 8'h0, "R1 slotTrig after reset", {24'h0, slotTrig}, 0);

    tickEn = 1'b1;
    // R3: first firing on the 4th tick for delay 4
    wr(0, 0, 32'h0100_0004 | KICK);
    idle(3);
    chk(slotTrig == 8'h00, "R3 no early fire", {24'h0, slotTrig}, 0);
    idle(1);
    chk(slotTrig == 8'h01, "R3 fire on tick D", {24'h0, slotTrig}, 1);
    idle(1);
    chk(slotTrig == 8'h00, "R4 single-cycle pulse", {24'h0, slotTrig}, 0);
    chk(dutWord[0] == 32'h0100_0004, "R5 kick cleared after one loop", dutWord[0], 32'h0100_0004);

    // R5: loop count 2 -> three firings
    clrCnt();
    wr(1, 0, 32'h0500_1003 | KICK);
    idle(15);
    chk(slotCnt[0] == 3, "R5 slot0 firings", slotCnt[0], 3);
    chk(slotCnt[2] == 3, "R5 slot2 firings", slotCnt[2], 3);
    chk(slotCnt[1] == 0, "R4 unmasked slot quiet", slotCnt[1], 0);
    chk(dutWord[1] == 32'h0500_1003, "R5 kick self-cleared", dutWord[1], 32'h0500_1003);

    // R6: self re-kick runs continuously
    clrCnt();
    wr(2, 0, 32'h1004_0802 | KICK);
    idle(20);
    chk(slotCnt[4] == 10, "R6 continuous firings", slotCnt[4], 10);
    chk(dutWord[2][20] == 1'b1, "R6 kick held", dutWord[2], 32'h1014_0802);
    // R7: clearing kick stops it
    wr(2, 2, KICK);
    clrCnt();
    idle(10);
    chk(slotCnt[4] == 0, "R7 stopped after clear", slotCnt[4], 0);
    chk(dutWord[2] == 32'h1004_0802, "R7 kick reads zero", dutWord[2], 32'h1004_0802);

    // R6: chain to another channel
    wr(3, 0, 32'h8000_0002);
    clrCnt();
    wr(2, 0, 32'h2008_0801 | KICK);
    idle(12);
    chk(slotCnt[5] == 2, "R6 source firings", slotCnt[5], 2);
    chk(slotCnt[7] == 1, "R6 chained firing", slotCnt[7], 1);
    chk(dutWord[3] == 32'h8000_0002, "R6 chained channel finished", dutWord[3], 32'h8000_0002);
    chk(dutWord[2] == 32'h2008_0801, "R6 source finished", dutWord[2], 32'h2008_0801);

    // R8: write wins over simultaneous chain kick
    clrCnt();
    wr(2, 0, 32'h2008_0001 | KICK);
    wr(3, 0, 32'h8000_0002);
    idle(6);
    chk(dutWord[3] == 32'h8000_0002, "R8 write beat chain kick", dutWord[3], 32'h8000_0002);
    chk(slotCnt[7] == 0, "R8 no chained firing", slotCnt[7], 0);

    // R7: rewriting kick does not restart the count
    wr(1, 0, 32'h0200_0005 | KICK);
    wr(1, 1, KICK);
    idle(3);
    chk(slotTrig == 8'h00, "R7 no fire before tick 5", {24'h0, slotTrig}, 0);
    idle(1);
    chk(slotTrig == 8'h02, "R7 fire on original schedule", {24'h0, slotTrig}, 2);

    // R2: write kinds
    wr(0, 0, 32'hFFEF_FFFF);
    idle(1);
    chk(dutWord[0] == 32'hFF0F_FFFF, "R2 replace and gap bits", dutWord[0], 32'hFF0F_FFFF);
    wr(0, 3, 32'h0);
    idle(1);
    chk(dutWord[0] == 32'hFF0F_FFFF, "R2 op3 no effect", dutWord[0], 32'hFF0F_FFFF);
    wr(0, 2, 32'h0F00_0F00);
    idle(1);
    chk(dutWord[0] == 32'hF00F_F0FF, "R2 clear bits", dutWord[0], 32'hF00F_F0FF);
    wr(0, 1, 32'h0F00_0000);
    idle(1);
    chk(dutWord[0] == 32'hFF0F_F0FF, "R2 set bits", dutWord[0], 32'hFF0F_F0FF);
    wr(0, 0, 32'h0);
    idle(1);
    chk(dutWord[0] == 32'h0, "R7 zero write disables", dutWord[0], 0);

    // random phase: model compared every cycle
    for (int i = 0; i < 3000; i++) begin
      tickEn = ($urandom % 2) == 1;
      if (($urandom % 10) < 4) begin
        regWrEn   = 1'b1;
        regWrChan = 2'($urandom % 4);
        regWrOp   = 2'($urandom % 4);
        regWrData = {8'($urandom), 3'($urandom), 1'($urandom), 4'($urandom),
                     5'($urandom % 4), 11'($urandom % 6)};
      end else begin
        regWrEn = 1'b0;
      end
      @(negedge clk); #1;
    end
    regWrEn = 1'b0;
    tickEn = 1'b0;
    idle(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule